// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of an integrating dual-slope converter. After a start request it first empties the external integrator capacitor. It then holds the input switch on the unknown signal for a fixed number of clock cycles. Next it swings the switch to the negative reference, so the capacitor ramps back down at a known constant slope. The block times that ramp with a counter that begins again from zero. A single comparator bit reports that the integrator has come back to zero, and that report ends the count.

The measured ramp length is published as the conversion code, together with a one-cycle completion pulse. The comparator bit arrives from the analog domain and passes through a short synchronizer. The block takes the delay of that synchronizer out of the count. If the ramp outlasts the code range, the block stops, reports full scale and raises an overflow flag. A conversion lasts hundreds of cycles, and each accepted request gives exactly one code.

Top module: `dual_slope_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `busy`, `done`, `sel_ref`, `int_reset` and `overflow` are low and `result` is zero.
- R2: A `start` sampled high while idle raises `busy` from the next cycle. `int_reset` is then high for exactly 2 consecutive cycles.
- R3: Right after the capacitor-clear cycles, the input phase runs for exactly `INT_TICKS` cycles. In this phase `busy` is high and `sel_ref`, `int_reset` and `done` are low.
- R4: `sel_ref` goes high directly after the input phase and stays high until the conversion ends. It lasts k+2 cycles for a code k of 1 or more, 1 cycle when the comparator already shows zero at entry, and 2^RES_W cycles on overflow.
- R5: The result is k. Here k counts the reference-phase cycles up to and including the first one at whose end `cmp_zero` (high = integrator at or below zero) is sampled high. The 2-cycle synchronizer delay is not counted. The result is 0 if `cmp_zero` is already high when the phase begins.
- R6: If k would be 2^RES_W-1 or more, `result` is all ones and `overflow` is 1. A conversion that ends normally leaves `overflow` at 0. A code of 2^RES_W-2 is still reported normally.
- R7: `done` is high for exactly one cycle per conversion, and `busy` is low in the cycle after it.
- R8: `result` and `overflow` change only in the cycle where `done` is high, and otherwise hold their value.
- R9: A `start` sampled while `busy` is high has no effect. The running conversion produces one `done` and the correct code, and no second conversion follows.
- R10: `sel_ref` and `int_reset` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, sampled when idle |
| cmp_zero | input | 1 | Asynchronous comparator bit, high when integrator has returned to zero |
| sel_ref | output | 1 | Switch select: 0 = unknown input, 1 = negative reference |
| int_reset | output | 1 | Discharges the integrator capacitor |
| busy | output | 1 | Conversion in progress |
| result | output | RES_W | Conversion code |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Last conversion ran past the code range |

## Verification
The sequencer's state and its single phase counter drive the switch lines directly. A wrong transition or a mistimed count therefore shows at once as a clear phase or input phase of the wrong length, or as `sel_ref` and `int_reset` overlapping. It also shows within the same conversion as a code that is off from the ceiling of INT_TICKS·Vin/Vref. A fault in the synchronizer compensation or in the end-of-range test moves the code by a fixed amount. The same fault also misreports the overflow flag at the 2^RES_W-2 / 2^RES_W-1 boundary, and that boundary is checked directly. Stray restarts show as extra `done` pulses in the cycles after a conversion.

// File: rtl/ds_ctrl_pkg.sv
`timescale 1ns/1ps
package ds_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_ACCUM,
    ST_DRAIN,
    ST_FINISH
  } ds_state_t;
endpackage

// File: rtl/ds_cmp_sync.sv
`timescale 1ns/1ps
module ds_cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ds_phase_cnt.sv
`timescale 1ns/1ps
module ds_phase_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/dual_slope_ctrl.sv
`timescale 1ns/1ps
module dual_slope_ctrl
  import ds_ctrl_pkg::*;
#(
  parameter int INT_TICKS   = 64,
  parameter int RES_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_zero,
  output logic             sel_ref,
  output logic             int_reset,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             done,
  output logic             overflow
);
  localparam int TICK_W   = $clog2(INT_TICKS + 1);
  localparam int PH_W     = (RES_W > TICK_W) ? RES_W : TICK_W;
  localparam int CLEAR_CYC = 2;
  localparam logic [PH_W-1:0] CLEAR_LAST = PH_W'(CLEAR_CYC - 1);
  localparam logic [PH_W-1:0] ACCUM_LAST = PH_W'(INT_TICKS - 1);
  localparam logic [PH_W-1:0] DRAIN_MAX  = PH_W'({RES_W{1'b1}});
  localparam logic [PH_W:0]   SYNC_LAT   = (PH_W+1)'(SYNC_STAGES);

  ds_state_t       st, nxt;
  logic [PH_W-1:0] cnt;
  logic            cmp_s;
  logic [PH_W:0]   elapsed;
  logic [PH_W:0]   measured;

  ds_cmp_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  (cmp_zero),
    .dout (cmp_s)
  );

  ds_phase_cnt #(.W(PH_W)) cnt_i (
    .clk (clk),
    .rst (rst),
    .clr (nxt != st),
    .en  (st != ST_IDLE),
    .cnt (cnt)
  );

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:   if (start)                       nxt = ST_CLEAR;
      ST_CLEAR:  if (cnt == CLEAR_LAST)           nxt = ST_ACCUM;
      ST_ACCUM:  if (cnt == ACCUM_LAST)           nxt = ST_DRAIN;
      ST_DRAIN:  if (cmp_s || cnt == DRAIN_MAX)   nxt = ST_FINISH;
      ST_FINISH:                                  nxt = ST_IDLE;
      default:                                    nxt = ST_IDLE;
    endcase
  end

  // cycles spent in the reference phase, minus the synchronizer delay
  always_comb begin
    elapsed  = (PH_W+1)'(cnt) + (PH_W+1)'(1);
    measured = (elapsed >= SYNC_LAT) ? (elapsed - SYNC_LAT) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      busy      <= 1'b0;
      sel_ref   <= 1'b0;
      int_reset <= 1'b0;
      done      <= 1'b0;
      result    <= '0;
      overflow  <= 1'b0;
    end else begin
      st        <= nxt;
      busy      <= (nxt != ST_IDLE);
      sel_ref   <= (nxt == ST_DRAIN);
      int_reset <= (nxt == ST_CLEAR);
      done      <= (nxt == ST_FINISH);
      if (st == ST_DRAIN && nxt == ST_FINISH) begin
        if (cmp_s) begin
          result   <= measured[RES_W-1:0];
          overflow <= 1'b0;
        end else begin
          result   <= '1;
          overflow <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dual_slope_ctrl_chk.sv
`timescale 1ns/1ps
module dual_slope_ctrl_chk #(
  parameter int RES_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             sel_ref,
  input logic             int_reset,
  input logic             busy,
  input logic [RES_W-1:0] result,
  input logic             done,
  input logic             overflow
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  // R7
  done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(result) && $stable(overflow)));

  // R6
  ovf_full_scale_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (result == {RES_W{1'b1}}));

  // R10
  switch_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sel_ref && int_reset));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sel_ref && !int_reset));

  // R2
  busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(start) && int_reset));

  // R3
  accum_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(int_reset) |-> (busy && !sel_ref && !done));

  // R4
  drain_after_accum_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_ref) |-> ($past(busy) && !$past(int_reset) && !$past(sel_ref)));
endmodule

bind dual_slope_ctrl dual_slope_ctrl_chk #(.RES_W(RES_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .sel_ref   (sel_ref),
  .int_reset (int_reset),
  .busy      (busy),
  .result    (result),
  .done      (done),
  .overflow  (overflow)
);

// File: tb/dual_slope_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_slope_ctrl_tb_top;
  localparam int N     = 64;
  localparam int RW    = 8;
  localparam int FULL  = (1 << RW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          cmp_zero;
  logic          sel_ref, int_reset, busy, done, overflow;
  logic [RW-1:0] result;

  int checks = 0;
  int fails  = 0;

  int acc = 0;
  int vin_cur = 0;
  int vref_cur = 64;
  int rs_cnt, in_cnt, sel_cnt, done_cnt;
  bit overlap;

  always #2 clk = ~clk;

  dual_slope_ctrl #(.INT_TICKS(N), .RES_W(RW), .SYNC_STAGES(2)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmp_zero  (cmp_zero),
    .sel_ref   (sel_ref),
    .int_reset (int_reset),
    .busy      (busy),
    .result    (result),
    .done      (done),
    .overflow  (overflow)
  );

  // integrator model and phase-length bookkeeping, one step per cycle
  initial cmp_zero = 1'b1;
  always @(negedge clk) begin
    if (int_reset)                   acc = 0;
    else if (busy && !sel_ref && !done) acc = acc + vin_cur;
    else if (sel_ref)                acc = acc - vref_cur;
    cmp_zero <= (acc <= 0);
    if (int_reset) rs_cnt++;
    if (busy && !sel_ref && !int_reset && !done) in_cnt++;
    if (sel_ref) sel_cnt++;
    if (done) done_cnt++;
    if ((sel_ref && int_reset) || (!busy && (sel_ref || int_reset))) overlap = 1'b1;
  end

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input int vin, input int vref);
    return (N * vin + vref - 1) / vref;
  endfunction

  task automatic convert(input int vin, input int vref, input bit poke);
    int k, exp_res, exp_sel, w;
    bit exp_ovf;
    logic [RW-1:0] snap;
    k = exp_code(vin, vref);
    exp_ovf = (k >= FULL);
    exp_res = exp_ovf ? FULL : k;
    exp_sel = exp_ovf ? (FULL + 1) : ((k == 0) ? 1 : k + 2);
    vin_cur = vin;
    vref_cur = vref;
    rs_cnt = 0; in_cnt = 0; sel_cnt = 0; done_cnt = 0; overlap = 1'b0;
    start = 1'b1;
    tick;
    start = 1'b0;
    tick;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    w = 0;
    while (!done && w < 2000) begin
      start = (poke && w == 20);
      tick;
      w++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R7 done seen", int'(done), 1);
    chk(int'(result) == exp_res, "R5 result", int'(result), exp_res);
    chk(overflow == exp_ovf, "R6 overflow", int'(overflow), int'(exp_ovf));
    chk(rs_cnt == 2, "R2 clear cycles", rs_cnt, 2);
    chk(in_cnt == N, "R3 input phase cycles", in_cnt, N);
    chk(sel_cnt == exp_sel, "R4 reference phase cycles", sel_cnt, exp_sel);
    snap = result;
    start = poke;
    tick;
    start = 1'b0;
    chk(done == 1'b0, "R7 done single cycle", int'(done), 0);
    chk(busy == 1'b0, "R7 busy low after done", int'(busy), 0);
    tick; tick; tick;
    chk(result == snap, "R8 result held", int'(result), int'(snap));
    chk(busy == 1'b0, "R9 no restart from busy start", int'(busy), 0);
    chk(done_cnt == 1, "R9 one done per start", done_cnt, 1);
    chk(overlap == 1'b0, "R10 switch exclusivity", int'(overlap), 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4480));
    rst = 1'b1;
    repeat (4) tick;
    chk(!busy && !done && !sel_ref && !int_reset && !overflow && result == '0,
        "R1 reset state", int'(result), 0);
    rst = 1'b0;
    tick;
    chk(!busy && !done && !sel_ref && !int_reset && !overflow && result == '0,
        "R1 after release", int'(busy), 0);

    // directed corners, Vref=64 gives code = Vin
    convert(100, 64, 1'b0);
    convert(0,   64, 1'b0);   // R5 zero input
    convert(1,   64, 1'b0);
    convert(254, 64, 1'b0);   // R6 last normal code
    convert(255, 64, 1'b1);   // R6 first overflow, R9 poke
    convert(37,  64, 1'b0);   // R6 flag clears
    convert(300, 64, 1'b0);
    convert(77,  50, 1'b1);   // R9 poke mid-conversion

    for (int i = 0; i < 24; i++) begin
      int vr, vi;
      vr = 16 + int'($urandom_range(0, 112));
      vi = int'($urandom_range(0, 320));
      convert(vi, vr, ($urandom_range(0, 3) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule